// File: doc/BRIEF.md
# Streaming 3x3 Median by Cumulative Histogram

The block takes the nine 8-bit grey pixels of a 3x3 neighbourhood as a stream and returns their median. It does not sort. It keeps one small counter per grey level, 256 in all. Each accepted pixel of value n adds one to every counter whose level is n or above, so after nine pixels counter k holds how many samples are at or below k. The median is the lowest level whose count has reached the median index, (9+1)/2 = 5. A priority encoder over the 256 "reached" flags finds that level.

Both edges of the block are valid/ready streams.

- **Input side.** A pixel is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_first` marks the first pixel of a window. The window closes by itself on its ninth accepted pixel.
- **Output side.** The result is registered. `out_valid` stays high with `out_median` frozen until `out_ready` is seen high.
- **Back-pressure.** While a result waits unconsumed, `in_ready` is low and no pixel is taken.
- **Gaps.** Cycles with `in_valid` low are idle and count for nothing.

Top module: `mhist_median`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and every bin is empty, so the first window counts only its own nine pixels.
- R2: When a window's ninth pixel is accepted, the result is the 5th smallest of the nine accepted values (the 5th entry of the list sorted ascending).
- R3: The window 156, 89, 75, 190, 204, 89, 89, 75, 255 yields 89.
- R4: `out_valid` rises in the clock cycle that follows the edge accepting the ninth pixel. It is never high earlier. With `out_ready` high it lasts exactly one cycle.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_median` hold and `in_ready` is 0. A pixel offered in this time is not counted.
- R6: A pixel accepted with `in_first`=1 empties all bins and counts as pixel 1 of a new window. Pixels of an unfinished earlier window are discarded.
- R7: Cycles with `in_valid`=0 change neither the bins nor the pixel count, so gaps between pixels do not alter the result.
- R8: The bins empty themselves after the ninth pixel. The next nine pixels form an independent window even without `in_first`.
- R9: Extremes: nine 0s give 0, nine 255s give 255, and a mix of only 0 and 255 gives whichever value occurs five or more times.
- R10: No bin counter ever exceeds 9.
- R11: A pixel of value n increments exactly the 256-n bins with level n through 255. This is a thermometer mask: the pixel's upper 3 bits pick a 32-bin segment, the lower 5 bits cut that segment, segments above are all ones and segments below are all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Block can take a pixel |
| in_first | input | 1 | Offered pixel starts a new window |
| in_pixel | input | 8 | Grey value of the offered pixel |
| out_valid | output | 1 | Median result available |
| out_ready | input | 1 | Consumer takes the result |
| out_median | output | 8 | Median of the last completed window |

## Verification
The assertions check on every cycle the properties that are local in time:
- bin counters stay bounded;
- each accepted pixel enables exactly 256-n bins;
- a stalled result holds its value and its valid;
- no pixel is accepted while a result is stalled;
- a result appears only after a ninth pixel, and that closing cycle always finds a level.

Only the bench's scenarios can show that the reported level is the true median of the window. That covers:
- random windows, checked against a sort;
- uniform windows at every one of the 256 grey levels;
- every 0/255 mix;
- the worked example;
- the effects of restarts, gaps and stalls on which pixels were counted.

// File: rtl/mhist_pkg.sv
package mhist_pkg;
  localparam int PIX_W   = 8;
  localparam int WIN     = 9;
  localparam int SEG_LOW = 5;
  localparam int NBINS   = 1 << PIX_W;
  localparam int CNT_W   = $clog2(WIN + 1);
  localparam int MED_IDX = (WIN + 1) / 2;
  localparam int POS_W   = $clog2(WIN);
endpackage

// File: rtl/mhist_mask.sv
module mhist_mask #(
  parameter int PIX_W   = 8,
  parameter int SEG_LOW = 5
) (
  input  logic [PIX_W-1:0]      pixel,
  output logic [(1<<PIX_W)-1:0] mask
);
  localparam int SEG_SZ = 1 << SEG_LOW;
  localparam int HI_W   = PIX_W - SEG_LOW;
  localparam int NSEG   = 1 << HI_W;

  logic [HI_W-1:0]    hi;
  logic [SEG_LOW-1:0] lo;
  logic [SEG_SZ-1:0]  part;

  assign hi   = pixel[PIX_W-1:SEG_LOW];
  assign lo   = pixel[SEG_LOW-1:0];
  assign part = {SEG_SZ{1'b1}} << lo;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    assign mask[k*SEG_SZ +: SEG_SZ] =
      (HI_W'(k) > hi)  ? {SEG_SZ{1'b1}} :
      (HI_W'(k) == hi) ? part : {SEG_SZ{1'b0}};
  end
endmodule

// File: rtl/mhist_bin.sv
module mhist_bin #(
  parameter int CNT_W = 4,
  parameter int LIMIT = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic             flush,
  input  logic [CNT_W-1:0] med_idx,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = (restart ? '0 : cnt_q) + CNT_W'(en);
  assign hit    = (cnt_nx >= med_idx);

  always_ff @(posedge clk) begin
    if (rst || flush) cnt_q <= '0;
    else              cnt_q <= cnt_nx;
  end

  // R10
  bin_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(LIMIT));
endmodule

// File: rtl/mhist_prienc.sv
module mhist_prienc #(
  parameter int N = 256
) (
  input  logic [N-1:0]         hit,
  output logic [$clog2(N)-1:0] idx,
  output logic                 found
);
  localparam int IDX_W = $clog2(N);

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mhist_median.sv
module mhist_median
  import mhist_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_first,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_median
);
  logic             accept, restart, last, found;
  logic [POS_W-1:0] pos_q;
  logic [NBINS-1:0] mask, hit;
  logic [PIX_W-1:0] level;
  logic             ov_q;
  logic [PIX_W-1:0] med_q;

  assign in_ready   = !ov_q || out_ready;
  assign accept     = in_valid && in_ready;
  assign restart    = accept && in_first;
  assign last       = accept && (in_first ? (WIN == 1) : (pos_q == POS_W'(WIN - 1)));
  assign out_valid  = ov_q;
  assign out_median = med_q;

  mhist_mask #(.PIX_W(PIX_W), .SEG_LOW(SEG_LOW)) u_mask (
    .pixel(in_pixel),
    .mask (mask)
  );

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    mhist_bin #(.CNT_W(CNT_W), .LIMIT(WIN)) u_bin (
      .clk    (clk),
      .rst    (rst),
      .en     (accept && mask[b]),
      .restart(restart),
      .flush  (last),
      .med_idx(CNT_W'(MED_IDX)),
      .hit    (hit[b])
    );
  end

  mhist_prienc #(.N(NBINS)) u_enc (
    .hit  (hit),
    .idx  (level),
    .found(found)
  );

  always_ff @(posedge clk) begin
    if (rst || last)   pos_q <= '0;
    else if (restart)  pos_q <= POS_W'(1);
    else if (accept)   pos_q <= pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q  <= 1'b0;
      med_q <= '0;
    end else if (last) begin
      ov_q  <= 1'b1;
      med_q <= level;
    end else if (out_ready) begin
      ov_q  <= 1'b0;
    end
  end

  // R11
  mask_width_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> ($countones(mask) == NBINS - int'(in_pixel)));
  // R2
  level_found_chk: assert property (@(posedge clk) disable iff (rst)
    last |-> found);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_median)));
  // R5
  no_take_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !(in_valid && in_ready));
  // R4
  valid_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(last));
endmodule

// File: tb/mhist_median_test.sv
module mhist_median_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_first = 1'b0;
  logic [7:0] in_pixel = '0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid;
  logic [7:0] out_median;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mhist_median uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_pixel(in_pixel), .out_valid(out_valid),
    .out_ready(out_ready), .out_median(out_median)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int med9(int v[9]);
    int a[9];
    a = v;
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 8 - i; j++)
        if (a[j] > a[j+1]) begin
          int t;
          t = a[j];
          a[j] = a[j+1];
          a[j+1] = t;
        end
    return a[4];
  endfunction

  // push one pixel, called at a negedge, returns at the following negedge
  task automatic push(int p, bit first, int gap);
    in_valid = 1'b1;
    in_first = first;
    in_pixel = p[7:0];
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic run_window(int v[9], string req, int gap, bit first);
    for (int i = 0; i < 9; i++) begin
      if (i == 8) check("R4", int'(out_valid), 0);
      push(v[i], first && (i == 0), (i == 8) ? 0 : gap);
    end
    check("R4", int'(out_valid), 1);
    check(req, int'(out_median), med9(v));
    @(negedge clk);
    check("R4", int'(out_valid), 0);
  endtask

  initial begin
    int v[9];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(in_ready), 1);

    // R3 worked example, first window after reset
    v = '{156, 89, 75, 190, 204, 89, 89, 75, 255};
    run_window(v, "R3", 0, 1'b0);
    check("R3", int'(out_median), 89);

    // R8 back-to-back windows without in_first, R2 random, R7 gaps
    for (int w = 0; w < 300; w++) begin
      for (int i = 0; i < 9; i++) v[i] = int'($urandom_range(0, 255));
      run_window(v, (w % 3 == 0) ? "R7" : "R8", w % 3, 1'b0);
    end

    // R9 uniform windows at every level, R11 mask edges
    for (int lv = 0; lv < 256; lv++) begin
      for (int i = 0; i < 9; i++) v[i] = lv;
      run_window(v, "R9", 0, 1'b1);
    end

    // R9 0/255 mixes
    for (int k = 0; k <= 9; k++) begin
      for (int i = 0; i < 9; i++) v[i] = (i < k) ? 0 : 255;
      run_window(v, "R9", 0, 1'b0);
      check("R9", int'(out_median), (k >= 5) ? 0 : 255);
    end

    // R6 abandon a partial window, restart with in_first
    for (int i = 0; i < 6; i++) push(0, 1'b0, 0);
    check("R6", int'(out_valid), 0);
    v = '{100, 100, 200, 200, 200, 100, 200, 100, 200};
    run_window(v, "R6", 0, 1'b1);
    check("R6", int'(out_median), 200);

    // R5 stall: result holds, in_ready low, offered pixel ignored
    out_ready = 1'b0;
    v = '{10, 20, 30, 40, 50, 60, 70, 80, 90};
    for (int i = 0; i < 9; i++) push(v[i], 1'b0, 0);
    check("R5", int'(out_valid), 1);
    check("R5", int'(out_median), 50);
    check("R5", int'(in_ready), 0);
    in_valid = 1'b1;
    in_pixel = 8'd0;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    check("R5", int'(out_valid), 1);
    check("R5", int'(out_median), 50);
    out_ready = 1'b1;
    @(negedge clk);
    check("R5", int'(out_valid), 0);
    v = '{0, 0, 0, 0, 255, 255, 255, 255, 255};
    run_window(v, "R5", 0, 1'b0);
    check("R5", int'(out_median), 255);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule